// File: doc/BRIEF.md
# Nested Priority Interrupt Controller with Tail-Chaining

This block sits beside a small processor core and decides which interrupt the core runs next. Each request line is edge-detected into a pending bit. Every source has a programmable priority. A grouping setting splits that priority into a preemption level and a subpriority. A single-cycle arbiter picks the most urgent pending source that is not masked. The controller keeps a stack of the priorities of the exceptions that are currently active. A new source is accepted only when its preemption level is more urgent than every active one. When that happens, the core is told to save its context.

When the core reports that a handler has finished, the controller looks again at every pending request before it tells the core to restore anything. If the best request is more urgent than all exceptions that remain underneath, the controller hands over the new vector straight away. The core then skips both the restore and the save, and the stack keeps its depth. Otherwise it orders a full restore and pops the stack. A threshold register holds back requests whose preemption level is not urgent enough. A global disable bit freezes both preemption and chaining. Requests that are held back stay pending.

Top module: `irq_chain_ctrl`

## Requirements
- R1: A pending bit is set only by a 0-to-1 transition of its request line. Holding the line high does not set it again. The bit is cleared in the cycle its vector is issued, whether by entry or by chaining.
- R2: Among eligible pending sources, the smallest full priority value wins. On equal values the lowest source number wins.
- R3: Entry of a new exception is allowed in two cases: the active stack is empty, or the candidate's preemption level is strictly smaller than the level of every active entry. On entry, take_o and stack_o pulse for one cycle with the vector, one cycle after the decision edge, and the candidate's priority is pushed onto the stack.
- R4: The grouping register (address NSRC) holds g, the number of low priority bits used as subpriority. Writes above PW are clamped to PW. The preemption level is priority >> g. Two sources that differ only in subpriority never preempt each other.
- R5: When ret_i is sampled with a non-empty stack, the controller may chain. It does so when the best eligible pending level is strictly smaller than every entry below the top, or when the top is the only entry and any eligible request is pending. On a chain, take_o and chain_o pulse together with the vector in the next cycle, stack_o stays low, and the top entry is replaced.
- R6: On a return where R5 does not apply (no eligible request, or a tie with or a loss to a remaining entry), unstack_o pulses alone in the next cycle and the stack is popped.
- R7: The threshold register (address NSRC+1) blocks a source when its preemption level is greater than or equal to the threshold. A threshold of 0 blocks nothing. Blocked sources stay pending.
- R8: While the disable bit (address NSRC+2, bit 0) is 1, no entry and no chaining occur, and every return produces an unstack. Pending requests are served once the bit is cleared.
- R9: An entry made when the stack already holds DEPTH entries still issues the vector. It does not store the priority, and it sets ovf_o, which stays set until reset.
- R10: After reset, all outputs are 0, and all priorities, grouping, threshold and disable settings are 0.
- R11: A return reported while the stack is empty does not produce an unstack or a chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NSRC+3) | 0..NSRC-1 priority, NSRC grouping, NSRC+1 threshold, NSRC+2 disable |
| cfg_data | input | PW | Write data |
| irq_i | input | NSRC | Request lines |
| ret_i | input | 1 | Handler-finished pulse from the core |
| take_o | output | 1 | Vector issue pulse (entry or chain) |
| take_vec_o | output | $clog2(NSRC) | Issued source number |
| stack_o | output | 1 | Core must save context (entry) |
| chain_o | output | 1 | Return resolved by chaining |
| unstack_o | output | 1 | Return resolved by full restore |
| ovf_o | output | 1 | Sticky active-stack overflow |

## Verification
The bench goes after a return whose pending candidate ties with the exception below the top. A design that compares with "less or equal" would chain there, and the exception it should return to would be skipped. It also checks a return with only one active entry: a design that always unstacks would lose the chain. Requests that differ only in subpriority must not preempt each other, and a design that compares full priorities would nest them. Masked requests, and requests held back by the disable bit, must remain pending; a design that drops them never serves them later. A run of nine nested entries must raise the overflow flag and still issue the vector.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    // Outcome of one decision cycle
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_ENTER = 2'd1,
        ACT_CHAIN = 2'd2,
        ACT_POP   = 2'd3
    } act_e;

    // Preemption level: priority with the subpriority bits shifted out
    function automatic logic [7:0] pre_lvl(input logic [7:0] prio, input logic [3:0] sub_bits);
        return prio >> sub_bits;
    endfunction

endpackage

// File: rtl/irq_chain_pend.sv
module irq_chain_pend #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] irq_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);
    logic [NSRC-1:0] irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= '0;
            pend_o <= '0;
        end else begin
            irq_q  <= irq_i;
            pend_o <= (pend_o & ~clr_i) | (irq_i & ~irq_q);
        end
    end

    // R1 / R7: a pending bit only leaves through an issue
    for (genvar g = 0; g < NSRC; g++) begin : g_hold
        a_r1_pend_holds: assert property (@(posedge clk) disable iff (rst)
            (pend_o[g] && !clr_i[g]) |=> pend_o[g]);
    end

endmodule

// File: rtl/irq_chain_arb.sv
module irq_chain_arb
    import irq_chain_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int PW   = 4,
    parameter int GW   = 3,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSRC-1:0]          pend_i,
    input  logic [NSRC-1:0][PW-1:0]  prio_i,
    input  logic [GW-1:0]            grp_i,
    input  logic [PW-1:0]            thr_i,
    output logic                     vld_o,
    output logic [IW-1:0]            idx_o,
    output logic [PW-1:0]            prio_o,
    output logic [PW-1:0]            lvl_o
);
    logic [NSRC-1:0]         elig;
    logic [NSRC-1:0][PW-1:0] lvl;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            lvl[i]  = PW'(pre_lvl(8'(prio_i[i]), 4'(grp_i)));
            elig[i] = pend_i[i] && !((thr_i != '0) && (lvl[i] >= thr_i));
        end
    end

    // Strict compare keeps the lowest index on equal priority
    always_comb begin
        vld_o  = 1'b0;
        idx_o  = '0;
        prio_o = '0;
        lvl_o  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!vld_o || prio_i[i] < prio_o)) begin
                vld_o  = 1'b1;
                idx_o  = IW'(i);
                prio_o = prio_i[i];
                lvl_o  = lvl[i];
            end
        end
    end

    a_r7_winner_unmasked: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (thr_i == '0 || lvl_o < thr_i));
    a_r2_winner_pending: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> pend_i[idx_o]);

endmodule

// File: rtl/irq_chain_stack.sv
module irq_chain_stack
    import irq_chain_pkg::*;
#(
    parameter int PW    = 4,
    parameter int DEPTH = 8,
    parameter int GW    = 3,
    localparam int DW   = $clog2(DEPTH + 1),
    localparam int SAW  = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          repl_i,
    input  logic [PW-1:0] prio_i,
    input  logic [GW-1:0] grp_i,
    output logic [DW-1:0] depth_o,
    output logic [PW-1:0] min_all_o,
    output logic [PW-1:0] min_below_o,
    output logic          ovf_o
);
    logic [DEPTH-1:0][PW-1:0] sprio;
    logic [PW-1:0]            lv;

    always_ff @(posedge clk) begin
        if (rst) begin
            sprio   <= '0;
            depth_o <= '0;
            ovf_o   <= 1'b0;
        end else if (push_i) begin
            if (depth_o == DW'(DEPTH)) begin
                ovf_o <= 1'b1;
            end else begin
                sprio[SAW'(depth_o)] <= prio_i;
                depth_o              <= depth_o + DW'(1);
            end
        end else if (pop_i && depth_o != '0) begin
            depth_o <= depth_o - DW'(1);
        end else if (repl_i && depth_o != '0) begin
            sprio[SAW'(depth_o - DW'(1))] <= prio_i;
        end
    end

    // Most urgent level over all entries and over entries below the top
    always_comb begin
        min_all_o   = '1;
        min_below_o = '1;
        lv          = '0;
        for (int i = 0; i < DEPTH; i++) begin
            lv = PW'(pre_lvl(8'(sprio[i]), 4'(grp_i)));
            if (i < int'(depth_o) && lv < min_all_o)
                min_all_o = lv;
            if (i + 1 < int'(depth_o) && lv < min_below_o)
                min_below_o = lv;
        end
    end

    a_r9_depth_bound: assert property (@(posedge clk) disable iff (rst)
        depth_o <= DW'(DEPTH));
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);
    a_r9_full_push: assert property (@(posedge clk) disable iff (rst)
        (push_i && depth_o == DW'(DEPTH)) |=> (ovf_o && $stable(depth_o)));

endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
    import irq_chain_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int PW    = 4,
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(NSRC),
    localparam int GW   = $clog2(PW + 1),
    localparam int AW   = $clog2(NSRC + 3),
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [PW-1:0]   cfg_data,
    input  logic [NSRC-1:0] irq_i,
    input  logic            ret_i,
    output logic            take_o,
    output logic [IW-1:0]   take_vec_o,
    output logic            stack_o,
    output logic            chain_o,
    output logic            unstack_o,
    output logic            ovf_o
);
    localparam int A_GRP = NSRC;
    localparam int A_THR = NSRC + 1;
    localparam int A_DIS = NSRC + 2;

    logic [NSRC-1:0][PW-1:0] prio_q;
    logic [GW-1:0]           grp_q;
    logic [PW-1:0]           thr_q;
    logic                    dis_q;

    logic [NSRC-1:0] pend, clr;
    logic            best_vld;
    logic [IW-1:0]   best_idx;
    logic [PW-1:0]   best_prio, best_lvl;
    logic [DW-1:0]   depth;
    logic [PW-1:0]   min_all, min_below;
    logic            chain_ok, enter_ok;
    act_e            act;

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
            grp_q  <= '0;
            thr_q  <= '0;
            dis_q  <= 1'b0;
        end else if (cfg_we) begin
            if (int'(cfg_addr) < NSRC)
                prio_q[IW'(cfg_addr)] <= cfg_data;
            else if (int'(cfg_addr) == A_GRP)
                grp_q <= (int'(cfg_data) > PW) ? GW'(PW) : GW'(cfg_data);
            else if (int'(cfg_addr) == A_THR)
                thr_q <= cfg_data;
            else if (int'(cfg_addr) == A_DIS)
                dis_q <= cfg_data[0];
        end
    end

    irq_chain_pend #(.NSRC(NSRC)) u_pend (
        .clk(clk), .rst(rst), .irq_i(irq_i), .clr_i(clr), .pend_o(pend)
    );

    irq_chain_arb #(.NSRC(NSRC), .PW(PW), .GW(GW)) u_arb (
        .clk(clk), .rst(rst), .pend_i(pend), .prio_i(prio_q), .grp_i(grp_q),
        .thr_i(thr_q), .vld_o(best_vld), .idx_o(best_idx), .prio_o(best_prio),
        .lvl_o(best_lvl)
    );

    irq_chain_stack #(.PW(PW), .DEPTH(DEPTH), .GW(GW)) u_stack (
        .clk(clk), .rst(rst),
        .push_i(act == ACT_ENTER), .pop_i(act == ACT_POP), .repl_i(act == ACT_CHAIN),
        .prio_i(best_prio), .grp_i(grp_q), .depth_o(depth),
        .min_all_o(min_all), .min_below_o(min_below), .ovf_o(ovf_o)
    );

    // Decision: a return is resolved first, otherwise preemption is tried
    always_comb begin
        chain_ok = !dis_q && best_vld && (depth == DW'(1) || best_lvl < min_below);
        enter_ok = !dis_q && best_vld && (depth == '0 || best_lvl < min_all);
        if (ret_i && depth != '0)
            act = chain_ok ? ACT_CHAIN : ACT_POP;
        else if (enter_ok)
            act = ACT_ENTER;
        else
            act = ACT_IDLE;
        clr = '0;
        if (act == ACT_ENTER || act == ACT_CHAIN)
            clr[best_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o     <= 1'b0;
            take_vec_o <= '0;
            stack_o    <= 1'b0;
            chain_o    <= 1'b0;
            unstack_o  <= 1'b0;
        end else begin
            take_o    <= (act == ACT_ENTER) || (act == ACT_CHAIN);
            stack_o   <= (act == ACT_ENTER);
            chain_o   <= (act == ACT_CHAIN);
            unstack_o <= (act == ACT_POP);
            if (act == ACT_ENTER || act == ACT_CHAIN)
                take_vec_o <= best_idx;
        end
    end

    a_r5_chain_no_save: assert property (@(posedge clk) disable iff (rst)
        chain_o |-> (take_o && !stack_o && !unstack_o));
    a_r6_unstack_alone: assert property (@(posedge clk) disable iff (rst)
        unstack_o |-> (!take_o && !chain_o));
    a_r8_disable_blocks: assert property (@(posedge clk) disable iff (rst)
        dis_q |=> !take_o);
    a_r11_empty_return: assert property (@(posedge clk) disable iff (rst)
        (ret_i && depth == '0) |=> !unstack_o && !chain_o);
    a_r3_entry_grows: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_ENTER && depth != DW'(DEPTH)) |=> depth == $past(depth) + DW'(1));

endmodule

// File: tb/irq_chain_ctrl_tb_top.sv
module irq_chain_ctrl_tb_top;
    localparam int NSRC  = 8;
    localparam int PW    = 4;
    localparam int DEPTH = 8;
    localparam int IW    = $clog2(NSRC);
    localparam int AW    = $clog2(NSRC + 3);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_we = 1'b0;
    logic [AW-1:0]   cfg_addr = '0;
    logic [PW-1:0]   cfg_data = '0;
    logic [NSRC-1:0] irq_i = '0;
    logic            ret_i = 1'b0;
    logic            take_o, stack_o, chain_o, unstack_o, ovf_o;
    logic [IW-1:0]   take_vec_o;

    always #4 clk = ~clk;

    irq_chain_ctrl #(.NSRC(NSRC), .PW(PW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .irq_i(irq_i), .ret_i(ret_i), .take_o(take_o),
        .take_vec_o(take_vec_o), .stack_o(stack_o), .chain_o(chain_o),
        .unstack_o(unstack_o), .ovf_o(ovf_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Transaction-level model state
    int m_prio[NSRC];
    bit m_pend[NSRC];
    int m_stk[DEPTH];
    int m_depth, m_grp, m_thr;
    bit m_dis, m_ovf;
    int exp_q[$];
    int obs_q[$];

    // Event codes: 100+v entry, 200+v chain, 300 unstack, 400+v malformed issue
    always @(negedge clk) begin
        if (!rst) begin
            if (take_o)
                obs_q.push_back(chain_o ? 200 + int'(take_vec_o)
                              : (stack_o ? 100 + int'(take_vec_o) : 400 + int'(take_vec_o)));
            if (unstack_o)
                obs_q.push_back(300);
        end
    end

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic int lvl(int p);
        return p >> m_grp;
    endfunction

    function automatic int m_best();
        int b = -1;
        for (int s = 0; s < NSRC; s++)
            if (m_pend[s] && !(m_thr != 0 && lvl(m_prio[s]) >= m_thr))
                if (b < 0 || m_prio[s] < m_prio[b]) b = s;
        return b;
    endfunction

    function automatic int min_stk(int n);
        int m = 99;
        for (int i = 0; i < n; i++)
            if (lvl(m_stk[i]) < m) m = lvl(m_stk[i]);
        return m;
    endfunction

    task automatic model_resolve(bit is_ret);
        int b;
        if (is_ret && m_depth > 0) begin
            b = m_best();
            if (!m_dis && b >= 0 && (m_depth == 1 || lvl(m_prio[b]) < min_stk(m_depth - 1))) begin
                exp_q.push_back(200 + b);
                m_pend[b] = 1'b0;
                m_stk[m_depth - 1] = m_prio[b];
            end else begin
                exp_q.push_back(300);
                m_depth--;
            end
        end
        for (int k = 0; k < 2 * NSRC; k++) begin
            b = m_best();
            if (m_dis || b < 0) break;
            if (m_depth > 0 && lvl(m_prio[b]) >= min_stk(m_depth)) break;
            exp_q.push_back(100 + b);
            m_pend[b] = 1'b0;
            if (m_depth == DEPTH) m_ovf = 1'b1;
            else begin
                m_stk[m_depth] = m_prio[b];
                m_depth++;
            end
        end
    endtask

    task automatic settle_and_compare(string tag);
        bit ok;
        int fa, fe;
        repeat (12) @(negedge clk);
        ok = (exp_q.size() == obs_q.size());
        fa = obs_q.size();
        fe = exp_q.size();
        if (ok) begin
            for (int i = 0; i < exp_q.size(); i++)
                if (exp_q[i] != obs_q[i]) begin
                    ok = 1'b0; fa = obs_q[i]; fe = exp_q[i]; break;
                end
        end
        chk(ok, tag, "event trace", fa, fe);
        chk(ovf_o == m_ovf, tag, "overflow flag", int'(ovf_o), int'(m_ovf));
        exp_q.delete();
        obs_q.delete();
    endtask

    task automatic op_irq(logic [NSRC-1:0] m, int hold, string tag);
        @(negedge clk) irq_i = m;
        repeat (hold) @(negedge clk);
        irq_i = '0;
        for (int s = 0; s < NSRC; s++) if (m[s]) m_pend[s] = 1'b1;
        model_resolve(1'b0);
        settle_and_compare(tag);
    endtask

    task automatic op_cfg(int addr, int data, string tag);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_data = PW'(data);
        @(negedge clk) cfg_we = 1'b0;
        if (addr < NSRC) m_prio[addr] = data;
        else if (addr == NSRC) m_grp = (data > PW) ? PW : data;
        else if (addr == NSRC + 1) m_thr = data;
        else m_dis = data[0];
        model_resolve(1'b0);
        settle_and_compare(tag);
    endtask

    task automatic op_ret(string tag);
        @(negedge clk) ret_i = 1'b1;
        @(negedge clk) ret_i = 1'b0;
        model_resolve(1'b1);
        settle_and_compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int r;
        for (int s = 0; s < NSRC; s++) begin m_prio[s] = 0; m_pend[s] = 1'b0; end
        m_depth = 0; m_grp = 0; m_thr = 0; m_dis = 1'b0; m_ovf = 1'b0;
        r = $urandom(32'h5EED_1234);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(take_o == 1'b0, "R10", "take_o", int'(take_o), 0);
        chk(unstack_o == 1'b0 && chain_o == 1'b0, "R10", "return outputs", int'(unstack_o | chain_o), 0);
        chk(ovf_o == 1'b0 && stack_o == 1'b0, "R10", "ovf/stack", int'(ovf_o | stack_o), 0);
        obs_q.delete();

        // R1: held line enters once
        op_cfg(3, 5, "R1");
        op_irq(8'h08, 6, "R1");
        op_ret("R6");
        // R2: equal priority, lowest index first; R5 chain at depth one
        op_cfg(2, 5, "R2");
        op_cfg(5, 5, "R2");
        op_irq(8'h24, 1, "R2");
        op_ret("R5");
        op_ret("R6");
        // R4 / R3: subpriority does not preempt
        op_cfg(NSRC, 1, "R4");
        op_cfg(1, 6, "R4");
        op_cfg(4, 7, "R4");
        op_irq(8'h02, 1, "R3");
        op_irq(8'h10, 1, "R3");
        op_ret("R5");
        op_cfg(0, 4, "R4");
        op_irq(8'h01, 1, "R3");
        op_ret("R6");
        op_ret("R6");
        // R6: tie with the remaining entry forces unstack
        op_irq(8'h02, 1, "R3");
        op_irq(8'h01, 1, "R3");
        op_irq(8'h10, 1, "R6");
        op_ret("R6");
        op_ret("R5");
        op_ret("R6");
        // R4 clamp of oversize grouping
        op_cfg(NSRC, 7, "R4");
        op_cfg(NSRC, 0, "R4");
        // R7: threshold
        op_cfg(6, 3, "R7");
        op_cfg(NSRC + 1, 3, "R7");
        op_irq(8'h40, 1, "R7");
        op_cfg(NSRC + 1, 2, "R7");
        op_cfg(NSRC + 1, 0, "R7");
        op_ret("R6");
        // R8: disable holds entry and chaining
        op_cfg(NSRC + 2, 1, "R8");
        op_irq(8'h80, 1, "R8");
        op_cfg(NSRC + 2, 0, "R8");
        op_cfg(NSRC + 2, 1, "R8");
        op_irq(8'h04, 1, "R8");
        op_ret("R8");
        op_cfg(NSRC + 2, 0, "R8");
        op_ret("R6");
        // R9: nine nested entries from one source
        for (int p = 8; p >= 0; p--) begin
            op_cfg(0, p, "R9");
            op_irq(8'h01, 1, "R9");
        end
        while (m_depth > 0) op_ret("R9");
        // R11: return with nothing active
        op_ret("R11");

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            r = int'($urandom % 10);
            if (r < 4 || (r < 7 && m_depth == 0))
                op_irq(NSRC'($urandom), 1, "R1 R2 R3");
            else if (r < 7)
                op_ret("R5 R6");
            else if (r == 7)
                op_cfg(int'($urandom % NSRC), int'($urandom % 16), "R2 R3");
            else if (r == 8)
                op_cfg(NSRC, int'($urandom % 6), "R4");
            else if ($urandom % 2 == 0)
                op_cfg(NSRC + 1, int'($urandom % 16) * int'($urandom % 2), "R7");
            else
                op_cfg(NSRC + 2, int'($urandom % 4 == 0), "R8");
        end
        op_cfg(NSRC + 2, 0, "R8");
        op_cfg(NSRC + 1, 0, "R7");
        while (m_depth > 0) op_ret("R5 R6");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule